// File: doc/BRIEF.md
# Synchronizable Clock Divider Bank with Re-timed SYSREF

This block holds a set of programmable integer dividers that all count on one fast clock. Each divider produces a divided clock level in the fast-clock domain. Left alone, a divide-by-D output can sit in any of D phases relative to the fast clock. A synchronization event forces every participating divider back to a common starting count, so outputs of equal value become edge-aligned and all outputs take a known phase.

A separate SYSREF divider (values 4 to 32) paces a capture register. An external request is sampled only when that divider restarts its count. This moves the setup and hold burden onto the slow divided edge instead of the fast clock. A rising edge of the re-timed request can trigger a divider sync, start a burst of SYSREF pulses, or be passed straight to the SYSREF output. Each output divider and the SYSREF divider carry a private sync-exclude bit. A typical use is a one-time local sync at start-up, after which the SYSREF divider is excluded so that later external requests realign only the clock outputs. A global enable gates every sync and SYSREF action.

Top module: `cdsync_bank`

## Requirements
- R1: An output divider programmed to D in 2..32 repeats with a period of D fast cycles and stays high for floor(D/2) cycles, starting high at its count restart. D = 1 holds the output high in every cycle that the divider is not in sync.
- R2: With the global enable set, a raised local sync holds every non-excluded output divider low. In the first cycle after release, all of them go high together and then follow the R1 pattern from that cycle.
- R3: An output divider whose exclude bit is set keeps its running phase through a sync event, with no hold and no restart.
- R4: The SYSREF divider takes part in a local sync unless its own exclude bit is set, in which case it keeps its phase. In continuous mode (mode code 2'b01), sysref_out repeats the SYSREF divider pattern (period S, high floor(S/2)) delayed by one fast cycle. After a local sync it first rises one cycle after the output dividers restart.
- R5: ext_req is sampled only at restarts of the SYSREF divider. With request sync enabled, a captured rising request holds the non-excluded output dividers low in the cycle after the next sysref_out rise (continuous mode). They restart in the cycle after that.
- R6: A request held high produces a single sync or a single pulse burst. It produces no repeated action at later SYSREF divider restarts.
- R7: In pulser mode (mode code 2'b10), a captured rising request yields exactly N whole SYSREF divider periods on sysref_out, N being the pulse-count value. A count of 0 yields one pulse.
- R8: In re-time mode (mode code 2'b11), sysref_out follows the captured request level and reaches it within S + 3 fast cycles of an ext_req change.
- R9: With the global enable clear, no sync acts (a D = 1 output stays high through a local sync) and sysref_out stays low.
- R10: sysref_out is low in off mode (mode code 2'b00). During reset, every divided output and sysref_out are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that all dividers count on |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync_en | input | 1 | Global enable for sync and SYSREF actions |
| cfg_sr_mode | input | 2 | SYSREF source: 00 off, 01 continuous, 10 pulser, 11 re-timed request |
| cfg_req_sync | input | 1 | A re-timed request rising edge syncs the dividers |
| cfg_local_sync | input | 1 | Level-held local sync request |
| cfg_div | input | NUM_OUT*DIV_W | Packed output divide values, output i at bits i*DIV_W upward |
| cfg_out_nosync | input | NUM_OUT | Per-output sync exclude bits |
| cfg_sr_div | input | DIV_W | SYSREF divider value |
| cfg_sr_nosync | input | 1 | Sync exclude bit of the SYSREF divider |
| cfg_pulse_cnt | input | CNT_W | Pulses per burst in pulser mode (0 means 1) |
| ext_req | input | 1 | External sync / SYSREF request |
| clk_out | output | NUM_OUT | Divided clock levels |
| sysref_out | output | 1 | SYSREF distribution output |

## Verification
Randomly chosen divide sets, together with the directed set {32, 2, 3, 1}, are restarted by local sync and compared cycle by cycle against the ideal pattern. This separates correct high-time and period arithmetic from off-by-one restarts, and the odd value shows the floor rule. Excluding one output divider and the SYSREF divider, each anchored on an observed rising edge before the sync, shows whether exclusion really preserves phase rather than merely delaying the restart. External requests held high in sync, pulser and re-time modes tell a single edge-qualified action apart from one repeated at every SYSREF restart. The D = 1 output exposes any extra hold, and pulse counts of 0, 3 and a random value check the burst length. Runs with the enable clear and with the mode set to off confirm that SYSREF stays silent.

// File: rtl/cdsync_pkg.sv
package cdsync_pkg;

   typedef enum logic [1:0] {
      SR_OFF    = 2'b00,
      SR_CONT   = 2'b01,
      SR_PULSE  = 2'b10,
      SR_RETIME = 2'b11
   } sr_mode_e;

   localparam int MAX_DIV = 32;

endpackage

// File: rtl/cdsync_div.sv
module cdsync_div #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             hold,
   output logic             clk_out,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] last_cnt;
   logic [DIV_W-1:0] cnt_nxt;
   logic [DIV_W-1:0] hi_len;

   // zero is treated as divide-by-one
   assign last_cnt = (div_val == '0) ? '0 : div_val - 1'b1;
   assign hi_len   = div_val >> 1;

   always_comb begin
      if (cnt_q >= last_cnt) cnt_nxt = '0;
      else                   cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clk_out <= 1'b0;
         tick    <= 1'b0;
      end else if (hold) begin
         // park on the last count so release restarts at zero
         cnt_q   <= last_cnt;
         clk_out <= 1'b0;
         tick    <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt;
         tick    <= (cnt_nxt == '0);
         clk_out <= (last_cnt == '0) ? 1'b1 : (cnt_nxt < hi_len);
      end
   end
endmodule

// File: rtl/cdsync_retime.sv
module cdsync_retime (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic req_in,
   output logic req_q,
   output logic req_rise
);
   logic req_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         req_d <= 1'b0;
      end else begin
         if (cap_en) req_q <= req_in;
         req_d <= req_q;
      end
   end

   assign req_rise = req_q & ~req_d;
endmodule

// File: rtl/cdsync_pulser.sv
module cdsync_pulser #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             start,
   input  logic             tick,
   input  logic [CNT_W-1:0] pulse_cnt,
   output logic             gate
);
   logic [CNT_W-1:0] remain_q;
   logic             gate_q;

   // the gate changes only at a divider restart so pulses are whole periods
   assign gate = tick ? (remain_q != '0) : gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         gate_q   <= 1'b0;
      end else if (clear) begin
         remain_q <= '0;
         gate_q   <= 1'b0;
      end else begin
         if (tick) gate_q <= gate;
         if (start)
            remain_q <= (pulse_cnt == '0) ? CNT_W'(1) : pulse_cnt;
         else if (tick && remain_q != '0)
            remain_q <= remain_q - 1'b1;
      end
   end
endmodule

// File: rtl/cdsync_bank.sv
module cdsync_bank
   import cdsync_pkg::*;
#(
   parameter int NUM_OUT    = 4,
   parameter int DIV_W      = 6,
   parameter int CNT_W      = 8,
   parameter bit HAS_PULSER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_sync_en,
   input  logic [1:0]               cfg_sr_mode,
   input  logic                     cfg_req_sync,
   input  logic                     cfg_local_sync,
   input  logic [NUM_OUT*DIV_W-1:0] cfg_div,
   input  logic [NUM_OUT-1:0]       cfg_out_nosync,
   input  logic [DIV_W-1:0]         cfg_sr_div,
   input  logic                     cfg_sr_nosync,
   input  logic [CNT_W-1:0]         cfg_pulse_cnt,
   input  logic                     ext_req,
   output logic [NUM_OUT-1:0]       clk_out,
   output logic                     sysref_out
);
   localparam int MIN_DIV_W = $clog2(MAX_DIV + 1);

   if (NUM_OUT < 1) begin : g_bad_num
      $error("cdsync_bank: NUM_OUT must be at least 1");
   end
   if (DIV_W < MIN_DIV_W) begin : g_bad_dw
      $error("cdsync_bank: DIV_W too narrow for the largest divide value");
   end
   if (CNT_W < 1) begin : g_bad_cw
      $error("cdsync_bank: CNT_W must be at least 1");
   end

   sr_mode_e           mode;
   logic               sync_evt;
   logic [NUM_OUT-1:0] out_hold;
   logic [NUM_OUT-1:0] out_tick;
   logic               sr_hold;
   logic               sr_clk;
   logic               sr_tick;
   logic               req_q;
   logic               req_rise;
   logic               pulse_gate;
   logic               sysref_d;

   assign mode     = sr_mode_e'(cfg_sr_mode);
   assign sync_evt = cfg_sync_en & (cfg_local_sync | (cfg_req_sync & req_rise));
   assign sr_hold  = sync_evt & ~cfg_sr_nosync;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign out_hold[i] = sync_evt & ~cfg_out_nosync[i];
      cdsync_div #(.DIV_W(DIV_W)) div_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .div_val (cfg_div[i*DIV_W +: DIV_W]),
         .hold    (out_hold[i]),
         .clk_out (clk_out[i]),
         .tick    (out_tick[i])
      );
   end

   cdsync_div #(.DIV_W(DIV_W)) sr_div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_val (cfg_sr_div),
      .hold    (sr_hold),
      .clk_out (sr_clk),
      .tick    (sr_tick)
   );

   cdsync_retime retime_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (sr_tick),
      .req_in   (ext_req),
      .req_q    (req_q),
      .req_rise (req_rise)
   );

   if (HAS_PULSER) begin : g_pulser
      cdsync_pulser #(.CNT_W(CNT_W)) pulser_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (!cfg_sync_en || mode != SR_PULSE),
         .start     (req_rise),
         .tick      (sr_tick),
         .pulse_cnt (cfg_pulse_cnt),
         .gate      (pulse_gate)
      );
   end else begin : g_no_pulser
      assign pulse_gate = 1'b0;
   end

   always_comb begin
      case (mode)
         SR_CONT:   sysref_d = sr_clk;
         SR_PULSE:  sysref_d = sr_clk & pulse_gate;
         SR_RETIME: sysref_d = req_q;
         default:   sysref_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sysref_out <= 1'b0;
      else        sysref_out <= sysref_d & cfg_sync_en;
   end
endmodule

// File: rtl/cdsync_bank_chk.sv
module cdsync_bank_chk #(
   parameter int NUM_OUT = 4,
   parameter int DIV_W   = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_sync_en,
   input logic [1:0]               cfg_sr_mode,
   input logic [NUM_OUT*DIV_W-1:0] cfg_div,
   input logic [NUM_OUT-1:0]       div_hold,
   input logic [NUM_OUT-1:0]       div_tick,
   input logic [NUM_OUT-1:0]       clk_out,
   input logic                     sysref_out
);
   // R9
   sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sync_en |=> !sysref_out);

   // R10
   sr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sr_mode == 2'b00) |=> !sysref_out);

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
      // R2
      hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         div_hold[i] |=> !clk_out[i]);

      // R2
      restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         div_hold[i] ##1 !div_hold[i] |=> clk_out[i]);

      // R1
      div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_div[i*DIV_W +: DIV_W] == DIV_W'(1) && !div_hold[i]) |=> clk_out[i]);

      // R1
      tick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         div_tick[i] |-> clk_out[i]);
   end
endmodule

bind cdsync_bank cdsync_bank_chk #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_sync_en (cfg_sync_en),
   .cfg_sr_mode (cfg_sr_mode),
   .cfg_div     (cfg_div),
   .div_hold    (out_hold),
   .div_tick    (out_tick),
   .clk_out     (clk_out),
   .sysref_out  (sysref_out)
);

// File: tb/cdsync_bank_tb_top.sv
module cdsync_bank_tb_top;
   localparam int NO = 4;
   localparam int DW = 6;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_sync_en = 1'b0;
   logic [1:0]    cfg_sr_mode = 2'b00;
   logic          cfg_req_sync = 1'b0;
   logic          cfg_local_sync = 1'b0;
   logic [NO*DW-1:0] cfg_div = '0;
   logic [NO-1:0] cfg_out_nosync = '0;
   logic [DW-1:0] cfg_sr_div = DW'(8);
   logic          cfg_sr_nosync = 1'b0;
   logic [CW-1:0] cfg_pulse_cnt = '0;
   logic          ext_req = 1'b0;
   logic [NO-1:0] clk_out;
   logic          sysref_out;

   int n_tests = 0;
   int n_fail  = 0;
   int ncyc    = 0;
   bit done    = 1'b0;
   int dv[NO];
   int sv = 8;

   always #5 clk = ~clk;

   cdsync_bank #(.NUM_OUT(NO), .DIV_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_sync_en(cfg_sync_en), .cfg_sr_mode(cfg_sr_mode),
      .cfg_req_sync(cfg_req_sync), .cfg_local_sync(cfg_local_sync), .cfg_div(cfg_div),
      .cfg_out_nosync(cfg_out_nosync), .cfg_sr_div(cfg_sr_div), .cfg_sr_nosync(cfg_sr_nosync),
      .cfg_pulse_cnt(cfg_pulse_cnt), .ext_req(ext_req), .clk_out(clk_out), .sysref_out(sysref_out)
   );

   task automatic step();
      @(negedge clk);
      ncyc++;
   endtask

   function automatic int exp_lvl(int k, int d);
      if (d == 1) return 1;
      return ((k % d) < (d / 2)) ? 1 : 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, ncyc);
      end
   endtask

   task automatic apply_cfg();
      for (int i = 0; i < NO; i++) cfg_div[i*DW +: DW] = dv[i][DW-1:0];
      cfg_sr_div = sv[DW-1:0];
   endtask

   // raise local sync for two edges, release, and stop in the restart cycle
   task automatic local_sync(string tag);
      cfg_local_sync = 1'b1;
      step();
      step();
      for (int i = 0; i < NO; i++)
         if (!cfg_out_nosync[i]) chk(tag, clk_out[i], 0);
      cfg_local_sync = 1'b0;
      step();
   endtask

   task automatic check_run(string tag, int len, int base[NO], int sbase, bit schk);
      for (int n = 0; n < len; n++) begin
         for (int i = 0; i < NO; i++) chk(tag, clk_out[i], exp_lvl(ncyc - base[i], dv[i]));
         if (schk && ncyc >= sbase) chk(tag, sysref_out, exp_lvl(ncyc - sbase, sv));
         step();
      end
   endtask

   task automatic wait_rise_out(int idx, output int at);
      logic prev;
      prev = clk_out[idx];
      at = -1;
      for (int n = 0; n < 80 && at < 0; n++) begin
         step();
         if (clk_out[idx] && !prev) at = ncyc;
         prev = clk_out[idx];
      end
   endtask

   task automatic wait_rise_sr(output int at);
      logic prev;
      prev = sysref_out;
      at = -1;
      for (int n = 0; n < 80 && at < 0; n++) begin
         step();
         if (sysref_out && !prev) at = ncyc;
         prev = sysref_out;
         chk("R5 no early sync", clk_out[NO-1], 1);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int base[NO];
      int r, sb, a0, cnt;
      logic prev;
      bit seen;
      void'($urandom(32'd4711));

      // reset state (R10)
      repeat (3) step();
      for (int i = 0; i < NO; i++) chk("R10 reset clk_out", clk_out[i], 0);
      chk("R10 reset sysref", sysref_out, 0);
      rst_n = 1'b1;
      cfg_sync_en = 1'b1;
      cfg_sr_mode = 2'b01;

      // R1 R2 R4: directed then random divide sets, restarted by local sync
      for (int it = 0; it < 6; it++) begin
         if (it == 0) begin
            dv[0] = 32; dv[1] = 2; dv[2] = 3; dv[3] = 1; sv = 4;
         end else begin
            for (int i = 0; i < NO - 1; i++) dv[i] = $urandom_range(1, 32);
            dv[NO-1] = 1;
            sv = $urandom_range(4, 32);
         end
         apply_cfg();
         repeat (5) step();
         local_sync("R2 hold");
         chk("R4 sysref at restart", sysref_out, 0);
         for (int i = 0; i < NO; i++) base[i] = ncyc;
         check_run("R1 R2 R4 pattern", 80, base, ncyc + 1, 1'b1);
      end

      // R3 R4: excluded output 0 and excluded SYSREF divider keep phase
      dv[0] = 7; dv[1] = 5; dv[2] = 12; dv[3] = 1; sv = 10;
      apply_cfg();
      repeat (3) step();
      cfg_out_nosync = 4'b0001;
      cfg_sr_nosync  = 1'b1;
      wait_rise_out(0, a0);
      wait_rise_sr(sb);
      local_sync("R3 hold");
      base[0] = a0;
      for (int i = 1; i < NO; i++) base[i] = ncyc;
      check_run("R3 R4 excluded phase", 70, base, sb, 1'b1);
      cfg_out_nosync = '0;

      // R5 R6: external request re-timed on SYSREF divider, held high
      dv[0] = 6; dv[1] = 9; dv[2] = 4; dv[3] = 1; sv = 8;
      apply_cfg();
      cfg_req_sync = 1'b1;
      repeat (2 * sv + 4) step();
      ext_req = 1'b1;
      wait_rise_sr(r);
      chk("R5 rise seen", (r > 0) ? 1 : 0, 1);
      step();
      for (int i = 0; i < NO; i++) chk("R5 hold", clk_out[i], 0);
      step();
      for (int i = 0; i < NO; i++) base[i] = ncyc;
      check_run("R5 R6 single sync", 5 * sv, base, r, 1'b1);
      ext_req = 1'b0;
      cfg_req_sync = 1'b0;
      repeat (2 * sv + 4) step();

      // R7 R6: pulser bursts with counts 3, 0 and random
      cfg_sr_mode = 2'b10;
      for (int t = 0; t < 3; t++) begin
         int nreq;
         nreq = (t == 0) ? 3 : (t == 1) ? 0 : $urandom_range(1, 6);
         cfg_pulse_cnt = CW'(nreq);
         repeat (2 * sv + 4) step();
         ext_req = 1'b1;
         cnt = 0;
         prev = sysref_out;
         for (int n = 0; n < (nreq + 4) * sv + 4; n++) begin
            step();
            if (sysref_out && !prev) cnt++;
            prev = sysref_out;
         end
         chk("R7 R6 pulse count", cnt, (nreq == 0) ? 1 : nreq);
         ext_req = 1'b0;
      end
      repeat (2 * sv + 4) step();

      // R8: re-timed request drives sysref_out
      cfg_sr_mode = 2'b11;
      step();
      chk("R8 idle low", sysref_out, 0);
      ext_req = 1'b1;
      seen = 1'b0;
      for (int n = 0; n < sv + 3; n++) begin
         step();
         if (sysref_out) seen = 1'b1;
      end
      chk("R8 follows high", seen, 1);
      repeat (sv) step();
      chk("R8 stays high", sysref_out, 1);
      ext_req = 1'b0;
      seen = 1'b0;
      for (int n = 0; n < sv + 3; n++) begin
         step();
         if (!sysref_out) seen = 1'b1;
      end
      chk("R8 follows low", seen, 1);

      // R9: global enable clear
      cfg_sr_mode = 2'b01;
      cfg_sync_en = 1'b0;
      step();
      for (int n = 0; n < 2 * sv; n++) begin
         step();
         chk("R9 sysref quiet", sysref_out, 0);
      end
      cfg_local_sync = 1'b1;
      for (int n = 0; n < 4; n++) begin
         step();
         chk("R9 no sync", clk_out[NO-1], 1);
      end
      cfg_local_sync = 1'b0;

      // R10: off mode
      cfg_sync_en = 1'b1;
      cfg_sr_mode = 2'b00;
      step();
      for (int n = 0; n < 2 * sv; n++) begin
         step();
         chk("R10 off mode", sysref_out, 0);
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule